// File: doc/BRIEF.md
# Single-Cycle Processor Control Decoder

This block is the control unit of a one-instruction-per-clock processor. It is purely combinational. It takes the six-bit operation field from the top of the instruction word (bits 31:26), the zero flag that the ALU computes from the first register operand, and a pending-interrupt request. From these it drives every steering and enable signal of the datapath: the ALU function code, the register-file write enable, the operand multiplexer selects, the write-back source, the data-memory write strobe, the next-PC source and the write-address select.

The decode is built in three stages:

- A classifier sorts the operation field into one of nine classes:
  - register ALU,
  - constant ALU,
  - load,
  - store,
  - jump,
  - branch-if-zero,
  - branch-if-nonzero,
  - PC-relative load,
  - illegal.
- A control table turns the class into a control word. The table resolves both conditional branches from the zero flag.
- An override stage replaces that word with a trap when an interrupt is pending.

A trap and an illegal-operation exception behave as a forced procedure call. Both write the return address (PC+4) into register 30 and both leave memory untouched. The register-field extraction, the ALU, the register file and the memories stay in the surrounding datapath.

Top module: `ctl_decode`

## Requirements
- R1: Operation fields 10xxxx (register ALU form) give werf=1, wdsel=1 (ALU result), bsel=0, ra2sel=0, asel=0, wasel=0, mem_wr=0, pcsel=0 (PC+4), and alufn equals the low four operation bits zero-extended to six.
- R2: Operation fields 11xxxx (constant ALU form) give the same controls as R1 except bsel=1 (sign-extended constant).
- R3: Load 011000 gives alufn=000000 (add), bsel=1, wdsel=2 (memory data), werf=1, mem_wr=0, pcsel=0, asel=0, wasel=0.
- R4: Store 011001 gives alufn=000000 (add), bsel=1, ra2sel=1, mem_wr=1, werf=0, pcsel=0.
- R5: Jump 011011 gives pcsel=2 (register target), werf=1, wdsel=0 (PC+4), mem_wr=0, wasel=0.
- R6: Branch-if-zero 011100 gives werf=1, wdsel=0 and mem_wr=0. Its pcsel is 1 (branch target) when alu_zero=1 and 0 otherwise.
- R7: Branch-if-nonzero 011101 gives werf=1, wdsel=0 and mem_wr=0. Its pcsel is 1 when alu_zero=0 and 0 otherwise.
- R8: PC-relative load 011111 gives asel=1, alufn=011010 (pass operand A), wdsel=2, werf=1, mem_wr=0, pcsel=0.
- R9: Every other operation field (all of 00xxxx and the unlisted 01xxxx codes) gives pcsel=3 (illegal-op vector), wasel=1 (register 30), werf=1, wdsel=0 and mem_wr=0.
- R10: With irq_pending=1, every operation field and zero-flag value give pcsel=4 (interrupt vector), wasel=1, werf=1, wdsel=0 and mem_wr=0. The instruction's own store is suppressed.
- R11: Controls that a class does not use are driven to 0: alufn, bsel, ra2sel and asel on jumps, branches and traps, and wdsel on stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Operation field, instruction bits 31:26 |
| alu_zero | input | 1 | Zero flag for the first register operand |
| irq_pending | input | 1 | Asynchronous interrupt awaiting service |
| alufn | output | 6 | ALU function code |
| werf | output | 1 | Register-file write enable |
| bsel | output | 1 | ALU B operand: 0 register, 1 constant |
| wdsel | output | 2 | Write-back source: 0 PC+4, 1 ALU, 2 memory |
| mem_wr | output | 1 | Data-memory write strobe |
| ra2sel | output | 1 | Second read address: 0 Rb field, 1 Rc field |
| pcsel | output | 3 | Next PC: 0 PC+4, 1 branch, 2 jump, 3 illegal-op, 4 interrupt |
| asel | output | 1 | ALU A operand: 0 register, 1 branch-target address |
| wasel | output | 1 | Write address: 0 Rc field, 1 register 30 |

## Verification
All 64 operation fields are applied under each of the four combinations of alu_zero and irq_pending.

- The sweep over opcodes separates the two ALU forms and the six named memory and control codes from the illegal ones. It covers the edges of the 01xxxx group, such as 011010 and 011110 lying next to legal codes.
- Toggling alu_zero on the two branch codes shows that each branch chooses the opposite polarity.
- On every other code, toggling alu_zero shows the flag has no effect.
- Raising irq_pending on the store and on the illegal codes shows that the interrupt wins over both, and that the write strobe is dropped.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int OP_W     = 6;
    localparam int ALUFN_W  = 6;
    localparam int PCSEL_W  = 3;
    localparam int WDSEL_W  = 2;

    localparam logic [ALUFN_W-1:0] ALUFN_ADD   = 6'b000000;
    localparam logic [ALUFN_W-1:0] ALUFN_PASSA = 6'b011010;

    typedef enum logic [3:0] {
        CLS_ALU_REG,
        CLS_ALU_CONST,
        CLS_LOAD,
        CLS_STORE,
        CLS_JUMP,
        CLS_BR_ZERO,
        CLS_BR_NONZERO,
        CLS_LOAD_REL,
        CLS_ILLEGAL
    } instr_class_e;

    typedef enum logic [PCSEL_W-1:0] {
        PC_NEXT   = 3'd0,
        PC_BRANCH = 3'd1,
        PC_JUMP   = 3'd2,
        PC_ILLOP  = 3'd3,
        PC_IRQ    = 3'd4
    } pc_src_e;

    typedef enum logic [WDSEL_W-1:0] {
        WD_RET = 2'd0,
        WD_ALU = 2'd1,
        WD_MEM = 2'd2
    } wd_src_e;

    typedef struct packed {
        logic [ALUFN_W-1:0] alufn;
        logic               werf;
        logic               bsel;
        wd_src_e            wdsel;
        logic               mem_wr;
        logic               ra2sel;
        pc_src_e            pcsel;
        logic               asel;
        logic               wasel;
    } ctl_word_t;

    localparam ctl_word_t CTL_IDLE = '{
        alufn:  ALUFN_ADD,
        werf:   1'b0,
        bsel:   1'b0,
        wdsel:  WD_RET,
        mem_wr: 1'b0,
        ra2sel: 1'b0,
        pcsel:  PC_NEXT,
        asel:   1'b0,
        wasel:  1'b0
    };

endpackage

// File: rtl/ctl_classify.sv
module ctl_classify
    import ctl_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output instr_class_e    cls_o
);

    always_comb begin
        unique casez (op_i)
            6'b10????: cls_o = CLS_ALU_REG;
            6'b11????: cls_o = CLS_ALU_CONST;
            6'b011000: cls_o = CLS_LOAD;
            6'b011001: cls_o = CLS_STORE;
            6'b011011: cls_o = CLS_JUMP;
            6'b011100: cls_o = CLS_BR_ZERO;
            6'b011101: cls_o = CLS_BR_NONZERO;
            6'b011111: cls_o = CLS_LOAD_REL;
            default:   cls_o = CLS_ILLEGAL;
        endcase
    end

    // R9
    always_comb begin
        if (op_i[5:4] == 2'b00) begin
            low_range_illegal_chk: assert (cls_o == CLS_ILLEGAL);
        end
    end

endmodule

// File: rtl/ctl_table.sv
module ctl_table
    import ctl_pkg::*;
(
    input  instr_class_e  cls_i,
    input  logic [3:0]    fn_i,
    input  logic          zero_i,
    output ctl_word_t     ctl_o
);

    localparam int FN_PAD = ALUFN_W - 4;

    always_comb begin
        ctl_o = CTL_IDLE;
        unique case (cls_i)
            CLS_ALU_REG, CLS_ALU_CONST: begin
                ctl_o.alufn = {{FN_PAD{1'b0}}, fn_i};
                ctl_o.werf  = 1'b1;
                ctl_o.wdsel = WD_ALU;
                ctl_o.bsel  = (cls_i == CLS_ALU_CONST);
            end
            CLS_LOAD: begin
                ctl_o.alufn = ALUFN_ADD;
                ctl_o.bsel  = 1'b1;
                ctl_o.werf  = 1'b1;
                ctl_o.wdsel = WD_MEM;
            end
            CLS_STORE: begin
                ctl_o.alufn  = ALUFN_ADD;
                ctl_o.bsel   = 1'b1;
                ctl_o.ra2sel = 1'b1;
                ctl_o.mem_wr = 1'b1;
            end
            CLS_JUMP: begin
                ctl_o.werf  = 1'b1;
                ctl_o.pcsel = PC_JUMP;
            end
            CLS_BR_ZERO: begin
                ctl_o.werf  = 1'b1;
                ctl_o.pcsel = zero_i ? PC_BRANCH : PC_NEXT;
            end
            CLS_BR_NONZERO: begin
                ctl_o.werf  = 1'b1;
                ctl_o.pcsel = zero_i ? PC_NEXT : PC_BRANCH;
            end
            CLS_LOAD_REL: begin
                ctl_o.alufn = ALUFN_PASSA;
                ctl_o.asel  = 1'b1;
                ctl_o.werf  = 1'b1;
                ctl_o.wdsel = WD_MEM;
            end
            CLS_ILLEGAL: begin
                ctl_o.werf  = 1'b1;
                ctl_o.wasel = 1'b1;
                ctl_o.pcsel = PC_ILLOP;
            end
            default: ctl_o = CTL_IDLE;
        endcase
    end

    // R4
    always_comb begin
        if (ctl_o.mem_wr) begin
            store_no_regwrite_chk: assert (!ctl_o.werf && cls_i == CLS_STORE);
        end
    end

    // R6
    always_comb begin
        if (ctl_o.pcsel == PC_BRANCH) begin
            branch_class_only_chk: assert (cls_i == CLS_BR_ZERO || cls_i == CLS_BR_NONZERO);
        end
    end

endmodule

// File: rtl/ctl_override.sv
module ctl_override
    import ctl_pkg::*;
(
    input  logic      irq_i,
    input  ctl_word_t ctl_i,
    output ctl_word_t ctl_o
);

    always_comb begin
        if (irq_i) begin
            ctl_o       = CTL_IDLE;
            ctl_o.werf  = 1'b1;
            ctl_o.wasel = 1'b1;
            ctl_o.pcsel = PC_IRQ;
        end else begin
            ctl_o = ctl_i;
        end
    end

    // R10
    always_comb begin
        if (irq_i) begin
            irq_no_store_chk: assert (!ctl_o.mem_wr && ctl_o.pcsel == PC_IRQ);
        end
    end

endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
    import ctl_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic       alu_zero,
    input  logic       irq_pending,
    output logic [5:0] alufn,
    output logic       werf,
    output logic       bsel,
    output logic [1:0] wdsel,
    output logic       mem_wr,
    output logic       ra2sel,
    output logic [2:0] pcsel,
    output logic       asel,
    output logic       wasel
);

    instr_class_e cls;
    ctl_word_t    base_ctl;
    ctl_word_t    final_ctl;

    ctl_classify u_classify (
        .op_i  (opcode),
        .cls_o (cls)
    );

    ctl_table u_table (
        .cls_i  (cls),
        .fn_i   (opcode[3:0]),
        .zero_i (alu_zero),
        .ctl_o  (base_ctl)
    );

    ctl_override u_override (
        .irq_i (irq_pending),
        .ctl_i (base_ctl),
        .ctl_o (final_ctl)
    );

    assign alufn  = final_ctl.alufn;
    assign werf   = final_ctl.werf;
    assign bsel   = final_ctl.bsel;
    assign wdsel  = final_ctl.wdsel;
    assign mem_wr = final_ctl.mem_wr;
    assign ra2sel = final_ctl.ra2sel;
    assign pcsel  = final_ctl.pcsel;
    assign asel   = final_ctl.asel;
    assign wasel  = final_ctl.wasel;

    // R9
    always_comb begin
        if (wasel) begin
            xp_write_returns_pc_chk: assert (werf && wdsel == 2'd0 && !mem_wr);
        end
    end

    // R9
    always_comb begin
        if (!irq_pending && cls == CLS_ILLEGAL) begin
            illop_vector_chk: assert (pcsel == 3'd3);
        end
    end

endmodule

// File: tb/ctl_decode_bench.sv
module ctl_decode_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode;
    logic       alu_zero;
    logic       irq_pending;
    logic [5:0] alufn;
    logic       werf, bsel, mem_wr, ra2sel, asel, wasel;
    logic [1:0] wdsel;
    logic [2:0] pcsel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ctl_decode u_ctl_decode (
        .opcode      (opcode),
        .alu_zero    (alu_zero),
        .irq_pending (irq_pending),
        .alufn       (alufn),
        .werf        (werf),
        .bsel        (bsel),
        .wdsel       (wdsel),
        .mem_wr      (mem_wr),
        .ra2sel      (ra2sel),
        .pcsel       (pcsel),
        .asel        (asel),
        .wasel       (wasel)
    );

    // packed: alufn, werf, bsel, wdsel, mem_wr, ra2sel, pcsel, asel, wasel
    function automatic logic [16:0] pack(int fn, int we, int bs, int wd, int wr,
                                         int r2, int pc, int as, int wa);
        return {fn[5:0], we[0], bs[0], wd[1:0], wr[0], r2[0], pc[2:0], as[0], wa[0]};
    endfunction

    function automatic logic [16:0] model(int op, bit z, bit irq, output string tag);
        if (irq) begin
            tag = "R10";
            return pack(0, 1, 0, 0, 0, 0, 4, 0, 1);
        end
        if (op >= 48) begin
            tag = "R2";
            return pack(op % 16, 1, 1, 1, 0, 0, 0, 0, 0);
        end
        if (op >= 32) begin
            tag = "R1";
            return pack(op % 16, 1, 0, 1, 0, 0, 0, 0, 0);
        end
        case (op)
            24: begin tag = "R3"; return pack(0, 1, 1, 2, 0, 0, 0, 0, 0); end
            25: begin tag = "R4"; return pack(0, 0, 1, 0, 1, 1, 0, 0, 0); end
            27: begin tag = "R5"; return pack(0, 1, 0, 0, 0, 0, 2, 0, 0); end
            28: begin tag = "R6"; return pack(0, 1, 0, 0, 0, 0, z ? 1 : 0, 0, 0); end
            29: begin tag = "R7"; return pack(0, 1, 0, 0, 0, 0, z ? 0 : 1, 0, 0); end
            31: begin tag = "R8"; return pack(26, 1, 0, 2, 0, 0, 0, 1, 0); end
            default: begin tag = "R9"; return pack(0, 1, 0, 0, 0, 0, 3, 0, 1); end
        endcase
    endfunction

    task automatic check_now(string extra);
        logic [16:0] got, exp;
        string tag;
        exp = model(int'(opcode), alu_zero, irq_pending, tag);
        got = {alufn, werf, bsel, wdsel, mem_wr, ra2sel, pcsel, asel, wasel};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s R11 %s op=%b z=%b irq=%b actual=%h expected=%h",
                     tag, extra, opcode, alu_zero, irq_pending, got, exp);
        end
    endtask

    initial begin
        opcode = 6'b011001;
        alu_zero = 1'b0;
        irq_pending = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_now("reset-phase interrupt over store");
        @(posedge clk);
        rst = 1'b0;
        for (int irq = 0; irq < 2; irq++) begin
            for (int z = 0; z < 2; z++) begin
                for (int op = 0; op < 64; op++) begin
                    @(posedge clk);
                    #1;
                    opcode = 6'(op);
                    alu_zero = z[0];
                    irq_pending = irq[0];
                    @(negedge clk);
                    check_now("sweep");
                end
            end
        end
        // branch polarity flips back to back (R6, R7)
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            #1;
            opcode = (k < 2) ? 6'b011100 : 6'b011101;
            alu_zero = k[0];
            irq_pending = 1'b0;
            @(negedge clk);
            check_now("branch flip");
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule